// File: doc/BRIEF.md
# Sequence Combination Lock

This block is a small state machine that releases a lock once four push buttons have been pressed in a set order. The order comes from an 8-bit code word that holds four 2-bit digits, and each digit names one of the four buttons. Six active-low seven-segment outputs show the word CLOSED while the lock is shut and OPEN once it has been released.

State changes happen only on clock edges where a one-cycle advance pulse from an external slow divider is high. The buttons are active low. At each such pulse the block compares the current button levels with the levels it stored at the previous pulse, and it acts only on buttons that have just gone down. A button that is held down therefore counts once. A wrong press clears all progress. Any press made while the lock is open shuts it again. A synchronous reset returns the block to its start state.

Top module: `seq_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the progress state becomes Start (no correct digits) and the stored button levels become all released. After that edge the display shows CLOSED.
- R2: On an edge where `tick` is low and `rst` is low, neither the progress state nor the stored button levels change.
- R3: Button i is pressed when `btn_n[i]` is 0. Digit k (k = 0 for the first) is `code[2k+1:2k]`. A new press with only the expected button down advances the state one step: Start, OneCorrect, TwoCorrect, ThreeCorrect, Unlocked.
- R4: The fourth correct press enters Unlocked. The display then shows OPEN: `disp5`..`disp2` = 1000000, 0001100, 0000110, 0101011, and `disp1` = `disp0` = 1111111. Segment bit 6 is g and bit 0 is a, and a 0 lights the segment.
- R5: A new press of any button other than the expected one, in any of the four locked states, returns the state to Start.
- R6: A new press made while more than one button is down counts as a wrong entry and returns the state to Start.
- R7: A press counts only on a released-to-pressed change between two ticks. A button held across several ticks counts once, and ticks with no newly pressed button leave the state unchanged.
- R8: In Unlocked, any new press, of any button or combination, returns the state to Start and the display to CLOSED.
- R9: In every state other than Unlocked, `disp5`..`disp0` = 1000110, 1000111, 1000000, 0010010, 0000110, 0100001 (C L O S E d).
- R10: Reset takes priority over `tick` and the buttons. A correct final press that comes with `rst` high does not open the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle advance pulse from the slow divider |
| code | input | 8 | Key word, four 2-bit digits, first digit in the low bits |
| btn_n | input | 4 | Push buttons, active low |
| disp5 | output | 7 | Leftmost digit segments, active low, g..a |
| disp4 | output | 7 | Digit 4 segments |
| disp3 | output | 7 | Digit 3 segments |
| disp2 | output | 7 | Digit 2 segments |
| disp1 | output | 7 | Digit 1 segments |
| disp0 | output | 7 | Rightmost digit segments |

## Verification
The bench targets these corner cases:
- A button held across several ticks. A design without edge detection would advance once per tick and open after a single long press.
- Two buttons pressed together, where one of them is the right one. A design that tests only the expected bit would advance here.
- Presses that arrive while `tick` is low. A design that stores button levels every clock would lose the press or count it twice.
- A final correct press made together with reset. If reset does not have priority, the lock opens for one cycle.
- Any press in the open state, including the first digit of the code. A design that decoded digits in Unlocked would step to OneCorrect instead of relocking.

// File: rtl/seq_lock.sv
module seq_lock #(
  parameter int NUM_BTN = 4,
  parameter int KEY_LEN = 4,
  localparam int DW     = $clog2(NUM_BTN),
  localparam int CW     = KEY_LEN * DW,
  localparam int PW     = $clog2(KEY_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [CW-1:0]      code,
  input  logic [NUM_BTN-1:0] btn_n,
  output logic [6:0]         disp5,
  output logic [6:0]         disp4,
  output logic [6:0]         disp3,
  output logic [6:0]         disp2,
  output logic [6:0]         disp1,
  output logic [6:0]         disp0
);
  localparam logic [PW-1:0] UNLOCKED = PW'(KEY_LEN);

  localparam logic [6:0] SEG_O = 7'b1000000;
  localparam logic [6:0] SEG_P = 7'b0001100;
  localparam logic [6:0] SEG_E = 7'b0000110;
  localparam logic [6:0] SEG_N = 7'b0101011;
  localparam logic [6:0] SEG_C = 7'b1000110;
  localparam logic [6:0] SEG_L = 7'b1000111;
  localparam logic [6:0] SEG_S = 7'b0010010;
  localparam logic [6:0] SEG_D = 7'b0100001;
  localparam logic [6:0] SEG_X = 7'b1111111;

  logic [PW-1:0]      progress;
  logic [NUM_BTN-1:0] held;
  logic [NUM_BTN-1:0] down;
  logic [NUM_BTN-1:0] fresh;
  logic [DW-1:0]      want;
  logic               hit;
  logic               is_open;

  assign down    = ~btn_n;
  assign fresh   = down & ~held;
  assign is_open = (progress == UNLOCKED);

  always_comb begin
    int idx;
    idx  = is_open ? 0 : int'(progress);
    want = code[idx*DW +: DW];
  end

  assign hit = $onehot(down) && down[want];

  always_ff @(posedge clk) begin
    if (rst) begin
      progress <= '0;
      held     <= '0;
    end else if (tick) begin
      held <= down;
      if (|fresh)
        progress <= (is_open || !hit) ? '0 : progress + PW'(1);
    end
  end

  assign disp5 = is_open ? SEG_O : SEG_C;
  assign disp4 = is_open ? SEG_P : SEG_L;
  assign disp3 = is_open ? SEG_E : SEG_O;
  assign disp2 = is_open ? SEG_N : SEG_S;
  assign disp1 = is_open ? SEG_X : SEG_E;
  assign disp0 = is_open ? SEG_X : SEG_D;
endmodule

// File: rtl/seq_lock_chk.sv
module seq_lock_chk #(
  parameter int NUM_BTN = 4,
  parameter int KEY_LEN = 4,
  parameter int PW      = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic [NUM_BTN-1:0] btn_n,
  input logic [NUM_BTN-1:0] held,
  input logic [PW-1:0]      progress,
  input logic [6:0]         disp5,
  input logic [6:0]         disp2,
  input logic [6:0]         disp0
);
  // R1
  reset_start_chk: assert property (@(posedge clk) rst |=> (progress == '0 && held == '0));

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(progress) && $stable(held)));

  // R7
  no_fresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && ((~btn_n & ~held) == '0)) |=> $stable(progress));

  // R3
  step_or_clear_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (progress == '0 || progress == $past(progress) + PW'(1) || progress == $past(progress)));

  // R8
  open_relock_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && progress == PW'(KEY_LEN) && |(~btn_n & ~held)) |=> progress == '0);

  // R6
  multi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && |(~btn_n & ~held) && $countones(~btn_n) > 1) |=> progress == '0);

  // R4
  open_disp_chk: assert property (@(posedge clk) disable iff (rst)
    progress == PW'(KEY_LEN) |-> (disp5 == 7'b1000000 && disp2 == 7'b0101011 && disp0 == 7'b1111111));

  // R9
  closed_disp_chk: assert property (@(posedge clk) disable iff (rst)
    progress != PW'(KEY_LEN) |-> (disp5 == 7'b1000110 && disp0 == 7'b0100001));
endmodule

bind seq_lock seq_lock_chk #(.NUM_BTN(NUM_BTN), .KEY_LEN(KEY_LEN), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .btn_n(btn_n), .held(held),
  .progress(progress), .disp5(disp5), .disp2(disp2), .disp0(disp0)
);

// File: tb/seq_lock_tb.sv
module seq_lock_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] code = 8'h00;
  logic [3:0] btn_n = 4'hF;
  logic [6:0] disp5, disp4, disp3, disp2, disp1, disp0;

  int n_tests = 0;
  int n_fail  = 0;
  int m_st    = 0;
  logic [3:0] m_held = 4'h0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_lock u_dut (
    .clk(clk), .rst(rst), .tick(tick), .code(code), .btn_n(btn_n),
    .disp5(disp5), .disp4(disp4), .disp3(disp3), .disp2(disp2), .disp1(disp1), .disp0(disp0)
  );

  function automatic logic [41:0] exp_disp(bit op);
    if (op) return {7'b1000000, 7'b0001100, 7'b0000110, 7'b0101011, 7'b1111111, 7'b1111111};
    return {7'b1000110, 7'b1000111, 7'b1000000, 7'b0010010, 7'b0000110, 7'b0100001};
  endfunction

  function automatic logic [3:0] digit_btn(logic [7:0] c, int k);
    return 4'b0001 << ((c >> (2*k)) & 8'h3);
  endfunction

  task automatic check(string tag);
    logic [41:0] got, exp;
    got = {disp5, disp4, disp3, disp2, disp1, disp0};
    exp = exp_disp(m_st == 4);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: display got %h expected %h (model state %0d)", tag, got, exp, m_st);
    end
  endtask

  task automatic expect_open(bit e, string tag);
    n_tests++;
    if ((m_st == 4) !== e || {disp5, disp4, disp3, disp2, disp1, disp0} !== exp_disp(e)) begin
      n_fail++;
      $display("FAIL %s: open got %0d expected %0d", tag, disp0 == 7'b1111111, e);
    end
  endtask

  task automatic step(logic [3:0] b, bit tk, bit r, string tag);
    logic [3:0] fr;
    @(negedge clk);
    btn_n = ~b; tick = tk; rst = r;
    @(posedge clk);
    if (r) begin
      m_st = 0; m_held = 4'h0;
    end else if (tk) begin
      fr = b & ~m_held;
      if (fr != 0) begin
        if (m_st == 4) m_st = 0;
        else if ($countones(b) == 1 && b == digit_btn(code, m_st)) m_st++;
        else m_st = 0;
      end
      m_held = b;
    end
    #1;
    check(tag);
  endtask

  task automatic press(logic [3:0] b, string tag);
    step(b, 1'b1, 1'b0, tag);
    step(4'h0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] b;
    void'($urandom(32'd20241));
    code = 8'b10_01_11_00;
    step(4'h0, 1'b0, 1'b1, "R1");
    step(4'h0, 1'b1, 1'b1, "R1");
    expect_open(1'b0, "R1 reset closed");

    // R3 R4 full sequence 0,3,1,2
    press(digit_btn(code, 0), "R3");
    press(digit_btn(code, 1), "R3");
    press(digit_btn(code, 2), "R3");
    expect_open(1'b0, "R3 three correct still closed");
    press(digit_btn(code, 3), "R4");
    expect_open(1'b1, "R4 open after fourth");

    // R8 relock with first digit button
    press(digit_btn(code, 0), "R8");
    expect_open(1'b0, "R8 relock");

    // R5 wrong second digit clears
    press(digit_btn(code, 0), "R5");
    press(4'b0001, "R5");
    press(digit_btn(code, 2), "R5");
    press(digit_btn(code, 3), "R5");
    expect_open(1'b0, "R5 wrong entry clears");

    // R6 two buttons including the right one
    press(digit_btn(code, 0), "R6");
    press(digit_btn(code, 1), "R6");
    press(digit_btn(code, 2) | 4'b0001, "R6");
    press(digit_btn(code, 3), "R6");
    expect_open(1'b0, "R6 multi press wrong");

    // R7 held button counts once
    step(digit_btn(code, 0), 1'b1, 1'b0, "R7");
    for (int i = 0; i < 3; i++) step(digit_btn(code, 0), 1'b1, 1'b0, "R7");
    step(4'h0, 1'b1, 1'b0, "R7");
    press(digit_btn(code, 1), "R7");
    press(digit_btn(code, 2), "R7");
    press(digit_btn(code, 3), "R7");
    expect_open(1'b1, "R7 held counted once");
    press(4'b1111, "R8");
    expect_open(1'b0, "R8 relock multi");

    // R2 no tick: press ignored until tick
    press(digit_btn(code, 0), "R2");
    press(digit_btn(code, 1), "R2");
    press(digit_btn(code, 2), "R2");
    step(digit_btn(code, 3), 1'b0, 1'b0, "R2");
    step(digit_btn(code, 3), 1'b0, 1'b0, "R2");
    expect_open(1'b0, "R2 no tick no change");
    step(digit_btn(code, 3), 1'b1, 1'b0, "R2");
    expect_open(1'b1, "R2 press counted at tick");
    step(4'h0, 1'b1, 1'b0, "R2");

    // R10 reset beats final press
    press(digit_btn(code, 0), "R10");
    press(digit_btn(code, 0), "R10");
    press(digit_btn(code, 0), "R10");
    press(digit_btn(code, 1), "R10");
    press(digit_btn(code, 2), "R10");
    step(digit_btn(code, 3), 1'b1, 1'b1, "R10");
    expect_open(1'b0, "R10 reset priority");
    step(4'h0, 1'b1, 1'b0, "R10");

    // R9 closed pattern with another code, random mix
    code = 8'b00_00_00_00;
    for (int n = 0; n < 4000; n++) begin
      if (n % 600 == 599) code = 8'($urandom);
      case ($urandom % 10)
        0, 1, 2, 3: b = digit_btn(code, (m_st == 4) ? 0 : m_st);
        4, 5, 6:    b = 4'h0;
        default:    b = 4'($urandom);
      endcase
      step(b, ($urandom % 10) < 7, ($urandom % 100) == 0, "R9 random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule